// File: doc/BRIEF.md
# PWM Channel Group Sequencer

This block coordinates a fixed set of PWM channel counters that belong to one group. It does not count periods itself. Each member channel reports the last clock of its period on a `period_end` bit. The sequencer answers with per-channel run, freeze and restart controls. Enabling the group sends one restart pulse to every member and then lets all of them run from the same clock edge. Three group modes shape the waveform after that:

- Hold lets each channel finish its current period, parks it, and raises an interrupt once all members are parked. While parked, it drives a programmable idle level.
- Round counts periods on the lead member (channel 0) and stops the group after a programmed number of them.
- Stop freezes every member on the spot.

The block also orders commits of pending channel settings. An update request is turned into a single group-wide commit strobe. When channels are generating, the strobe is aligned to a period boundary of the lead member. When they are not, it is issued at once. The channel count is a parameter: four for ordinary groups, six for the wide one. Channels outside any group are simply not wired to an instance.

Top module: `pwm_grp_ctrl`

## Requirements
- R1: After reset, every output is 0 (`ch_run`, `ch_freeze`, `ch_restart`, `idle_ovr`, `idle_lvl`, `commit`, `irq`).
- R2: When `grp_en` is sampled high while idle, `ch_restart` is all ones for exactly one cycle. In the following cycle, `ch_run` is all ones for every member together.
- R3: While `hold_req` is high and `stop_req` is low, each member's `ch_run` bit drops in the cycle after its own `period_end` pulse. Once every member has ended a period, the group enters hold on the next edge: `ch_run` is 0, `idle_ovr` is 1, `idle_lvl` follows `idle_level`, and `irq` becomes 1.
- R4: Lowering `hold_req` while in hold produces one cycle of all-ones `ch_restart`, then all-ones `ch_run`.
- R5: In a cycle where the group is generating and `stop_req` is high, `ch_freeze` is all ones and `ch_run` is 0. Lowering `stop_req` restores all-ones `ch_run` in that same cycle.
- R6: Stop outranks hold. While `stop_req` is high, `period_end` pulses neither park channels nor advance the round count, and the group does not begin draining.
- R7: With `round_num` = N > 0, the N-th lead-channel `period_end` that is counted moves the group to a finished state on the next edge. The lead channel is bit 0. The count restarts at every restart pulse. In the finished state, `ch_run` and `ch_freeze` are 0, and the state persists while `grp_en` stays high.
- R8: With `round_num` = 0, the group runs indefinitely, whatever the number of periods.
- R9: Each `upd_req` pulse yields exactly one `commit` pulse. While generating, `commit` is issued in the cycle of the next lead `period_end`. Otherwise it is issued in the cycle after the request.
- R10: `irq` stays 1 until a cycle with `irq_clr` high. It is 0 in the following cycle unless a new hold entry sets it again in that same cycle, in which case it stays 1.
- R11: Sampling `grp_en` low returns the group to idle on the next edge from any state, with `ch_run` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_en | input | 1 | Group enable; rising use starts synchronous generation |
| hold_req | input | 1 | Request to park the group at period ends |
| stop_req | input | 1 | Immediate freeze request |
| idle_level | input | 1 | Output level to drive while held |
| round_num | input | RND_W | Period count for round mode, 0 = unlimited |
| upd_req | input | 1 | Request to commit pending channel settings |
| irq_clr | input | 1 | Write-one-to-clear for the interrupt flag |
| period_end | input | NUM_CH | Per-channel last-cycle-of-period pulse |
| ch_run | output | NUM_CH | Per-channel count enable |
| ch_freeze | output | NUM_CH | Per-channel freeze (hold current output level) |
| ch_restart | output | NUM_CH | Per-channel counter restart |
| idle_ovr | output | 1 | Override channel outputs with the idle level |
| idle_lvl | output | 1 | Idle level to drive while the override is active |
| commit | output | 1 | Group-wide shadow register commit strobe |
| irq | output | 1 | Sticky hold-entry interrupt |

## Verification
The bench targets staggered period ends during hold. A design that parked the whole group on the first pulse, or raised the interrupt early, would show `ch_run` falling on all bits at once and `irq` set before the last member ended.

It also applies stop and hold together and pulses `period_end` during the stop. A design that let hold win would start draining or park members, so `ch_run` would come back partially set when stop drops.

The round test feeds leader-only pulses and checks that the stop lands after exactly the third. An off-by-one counter would stop a period early or late. The bench further times the commit strobe against a delayed lead pulse and against the hold state. A design that committed immediately, or twice per request, would produce `commit` in the wrong cycle.

// File: rtl/pwm_grp_pkg.sv
package pwm_grp_pkg;
  typedef enum logic [2:0] {
    GS_IDLE  = 3'd0,
    GS_START = 3'd1,
    GS_RUN   = 3'd2,
    GS_DRAIN = 3'd3,
    GS_HOLD  = 3'd4,
    GS_DONE  = 3'd5
  } grp_state_e;

  function automatic logic is_generating(grp_state_e s);
    return (s == GS_RUN) || (s == GS_DRAIN);
  endfunction
endpackage

// File: rtl/pwm_grp_round.sv
module pwm_grp_round #(
  parameter int RND_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_clr,
  input  logic             cnt_en,
  input  logic [RND_W-1:0] round_num,
  output logic             round_hit
);
  logic [RND_W-1:0] cnt_q, cnt_d;
  logic             limit_on;

  assign limit_on  = (round_num != '0);
  assign round_hit = cnt_en && limit_on && (cnt_q == round_num - RND_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_clr)     cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + RND_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (cnt_clr || cnt_en) cnt_q <= cnt_d;
  end

  // R7: the counter never wraps past a nonzero limit without a hit
  p_round_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !cnt_clr && limit_on && cnt_q == round_num - RND_W'(1)) |-> round_hit);
endmodule

// File: rtl/pwm_grp_commit.sv
module pwm_grp_commit (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_req,
  input  logic generating,
  input  logic lead_end,
  output logic commit
);
  logic pend_q, pend_d;

  assign commit = pend_q && (!generating || lead_end);

  always_comb begin
    pend_d = pend_q;
    if (commit)  pend_d = 1'b0;
    if (upd_req) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  // R9: one request gives one strobe
  p_commit_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !upd_req) |=> !commit);
  // R9: no strobe mid-period while generating
  p_commit_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && generating) |-> lead_end);
endmodule

// File: rtl/pwm_grp_seq.sv
module pwm_grp_seq
  import pwm_grp_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grp_en,
  input  logic              hold_req,
  input  logic              stop_req,
  input  logic [NUM_CH-1:0] period_end,
  input  logic              round_hit,
  output grp_state_e        state_o,
  output logic [NUM_CH-1:0] ch_run,
  output logic [NUM_CH-1:0] ch_freeze,
  output logic [NUM_CH-1:0] ch_restart,
  output logic              cnt_en,
  output logic              cnt_clr,
  output logic              hold_entry
);
  localparam logic [NUM_CH-1:0] ALL_CH = {NUM_CH{1'b1}};
  localparam int                LEAD   = 0;

  grp_state_e        state_q, state_d;
  logic [NUM_CH-1:0] park_q, park_d;
  logic              gen, live;

  assign gen     = is_generating(state_q);
  assign live    = gen && !stop_req;
  assign cnt_en  = live && period_end[LEAD];
  assign cnt_clr = (state_q == GS_START);
  assign state_o = state_q;

  always_comb begin
    state_d    = state_q;
    park_d     = park_q;
    hold_entry = 1'b0;
    unique case (state_q)
      GS_IDLE:  state_d = GS_START;
      GS_START: begin
        state_d = GS_RUN;
        park_d  = '0;
      end
      GS_RUN: if (!stop_req) begin
        if (round_hit) state_d = GS_DONE;
        else if (hold_req) begin
          state_d = GS_DRAIN;
          park_d  = period_end;
        end
      end
      GS_DRAIN: if (!stop_req) begin
        if (round_hit) state_d = GS_DONE;
        else begin
          park_d = park_q | period_end;
          if ((park_q | period_end) == ALL_CH) begin
            state_d    = GS_HOLD;
            hold_entry = grp_en;
          end
        end
      end
      GS_HOLD:  if (!hold_req && !stop_req) state_d = GS_START;
      GS_DONE:  state_d = GS_DONE;
      default:  state_d = GS_IDLE;
    endcase
    if (!grp_en) begin
      state_d    = GS_IDLE;
      hold_entry = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GS_IDLE;
      park_q  <= '0;
    end else begin
      state_q <= state_d;
      park_q  <= park_d;
    end
  end

  always_comb begin
    ch_run     = '0;
    ch_freeze  = '0;
    ch_restart = (state_q == GS_START) ? ALL_CH : '0;
    if (gen && stop_req)        ch_freeze = ALL_CH;
    else if (state_q == GS_RUN)   ch_run = ALL_CH;
    else if (state_q == GS_DRAIN) ch_run = ~park_q;
  end

  // R5: a channel is never both counting and frozen
  p_run_frz_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_run & ch_freeze) == '0);
  // R2: restart is followed by synchronous generation
  p_start_to_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == GS_START && grp_en) |=> (state_q == GS_RUN));
  // R6: stop blocks the move into drain
  p_stop_beats_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == GS_RUN && stop_req) |=> (state_q == GS_RUN || state_q == GS_IDLE));
  // R11: disabling the group always lands in idle
  p_disable_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_en |=> (state_q == GS_IDLE));
endmodule

// File: rtl/pwm_grp_ctrl.sv
module pwm_grp_ctrl
  import pwm_grp_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int RND_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grp_en,
  input  logic              hold_req,
  input  logic              stop_req,
  input  logic              idle_level,
  input  logic [RND_W-1:0]  round_num,
  input  logic              upd_req,
  input  logic              irq_clr,
  input  logic [NUM_CH-1:0] period_end,
  output logic [NUM_CH-1:0] ch_run,
  output logic [NUM_CH-1:0] ch_freeze,
  output logic [NUM_CH-1:0] ch_restart,
  output logic              idle_ovr,
  output logic              idle_lvl,
  output logic              commit,
  output logic              irq
);
  grp_state_e state;
  logic       cnt_en, cnt_clr, round_hit, hold_entry;
  logic       irq_q, irq_d;

  pwm_grp_seq #(.NUM_CH(NUM_CH)) u_seq (
    .clk(clk), .rst_n(rst_n), .grp_en(grp_en), .hold_req(hold_req),
    .stop_req(stop_req), .period_end(period_end), .round_hit(round_hit),
    .state_o(state), .ch_run(ch_run), .ch_freeze(ch_freeze),
    .ch_restart(ch_restart), .cnt_en(cnt_en), .cnt_clr(cnt_clr),
    .hold_entry(hold_entry)
  );

  pwm_grp_round #(.RND_W(RND_W)) u_round (
    .clk(clk), .rst_n(rst_n), .cnt_clr(cnt_clr), .cnt_en(cnt_en),
    .round_num(round_num), .round_hit(round_hit)
  );

  pwm_grp_commit u_commit (
    .clk(clk), .rst_n(rst_n), .upd_req(upd_req),
    .generating(is_generating(state)), .lead_end(period_end[0]),
    .commit(commit)
  );

  assign idle_ovr = (state == GS_HOLD);
  assign idle_lvl = idle_ovr && idle_level;

  always_comb begin
    irq_d = irq_q;
    if (irq_clr)    irq_d = 1'b0;
    if (hold_entry) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end
  assign irq = irq_q;

  // R10: the flag only drops on an explicit clear
  p_irq_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);
  // R3: no member counts while the idle level is forced
  p_hold_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    idle_ovr |-> (ch_run == '0 && ch_freeze == '0));
  // R7: the finished state drives nothing
  p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == GS_DONE) |-> (ch_run == '0 && ch_freeze == '0));
endmodule

// File: tb/pwm_grp_ctrl_tb.sv
module pwm_grp_ctrl_tb;
  localparam int N  = 4;
  localparam int RW = 8;

  logic          clk = 1'b0;
  logic          rst_n, grp_en, hold_req, stop_req, idle_level, upd_req, irq_clr;
  logic [RW-1:0] round_num;
  logic [N-1:0]  period_end;
  logic [N-1:0]  ch_run, ch_freeze, ch_restart;
  logic          idle_ovr, idle_lvl, commit, irq;

  pwm_grp_ctrl #(.NUM_CH(N), .RND_W(RW)) u_dut (
    .clk(clk), .rst_n(rst_n), .grp_en(grp_en), .hold_req(hold_req),
    .stop_req(stop_req), .idle_level(idle_level), .round_num(round_num),
    .upd_req(upd_req), .irq_clr(irq_clr), .period_end(period_end),
    .ch_run(ch_run), .ch_freeze(ch_freeze), .ch_restart(ch_restart),
    .idle_ovr(idle_ovr), .idle_lvl(idle_lvl), .commit(commit), .irq(irq)
  );

  always #10 clk = ~clk;

  typedef struct {
    int         tgt;
    logic [N-1:0] run, frz, rst;
    logic       ovr, lvl, cmt, irq;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare outputs against queued expectations mid-cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].tgt <= cyc) begin
      exp_t e;
      logic [3*N+3:0] act, exv;
      e = q.pop_front();
      act = {ch_run, ch_freeze, ch_restart, idle_ovr, idle_lvl, commit, irq};
      exv = {e.run, e.frz, e.rst, e.ovr, e.lvl, e.cmt, e.irq};
      n_chk++;
      if (e.tgt != cyc || act !== exv) begin
        n_fail++;
        $display("FAIL %s: run/frz/rst/ovr/lvl/cmt/irq actual %b expected %b (cycle %0d)",
                 e.tag, act, exv, cyc);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // driver side: push the expected view for the current cycle
  task automatic expect_out(input logic [N-1:0] run, input logic [N-1:0] frz,
                            input logic [N-1:0] rst, input logic ovr, input logic lvl,
                            input logic cmt, input logic irq_e, input string tag);
    exp_t e;
    e.tgt = cyc; e.run = run; e.frz = frz; e.rst = rst;
    e.ovr = ovr; e.lvl = lvl; e.cmt = cmt; e.irq = irq_e; e.tag = tag;
    q.push_back(e);
  endtask

  localparam logic [N-1:0] F = '1;
  localparam logic [N-1:0] Z = '0;

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; grp_en = 0; hold_req = 0; stop_req = 0; idle_level = 0;
    upd_req = 0; irq_clr = 0; round_num = '0; period_end = '0;
    tick(); tick();
    expect_out(Z, Z, Z, 0, 0, 0, 0, "R1 in reset");
    rst_n = 1'b1;
    tick();
    expect_out(Z, Z, Z, 0, 0, 0, 0, "R1 after reset");
    grp_en = 1;
    tick(); expect_out(Z, Z, F, 0, 0, 0, 0, "R2 restart pulse");
    tick(); expect_out(F, Z, Z, 0, 0, 0, 0, "R2 synchronous run");
    tick(); period_end = F; expect_out(F, Z, Z, 0, 0, 0, 0, "R8 running");
    tick(); period_end = Z; upd_req = 1; expect_out(F, Z, Z, 0, 0, 0, 0, "R9 request");
    tick(); upd_req = 0; expect_out(F, Z, Z, 0, 0, 0, 0, "R9 waits for boundary");
    tick(); period_end = F; expect_out(F, Z, Z, 0, 0, 1, 0, "R9 commit at lead end");
    tick(); period_end = Z; expect_out(F, Z, Z, 0, 0, 0, 0, "R9 single strobe");
    // stop
    tick(); stop_req = 1; expect_out(Z, F, Z, 0, 0, 0, 0, "R5 freeze");
    tick(); period_end = 4'b0001; expect_out(Z, F, Z, 0, 0, 0, 0, "R5 still frozen");
    tick(); period_end = Z; stop_req = 0; expect_out(F, Z, Z, 0, 0, 0, 0, "R5 resume");
    // stop and hold together
    tick(); stop_req = 1; hold_req = 1; idle_level = 1;
    expect_out(Z, F, Z, 0, 0, 0, 0, "R6 stop wins");
    tick(); period_end = F; expect_out(Z, F, Z, 0, 0, 0, 0, "R6 pulses ignored");
    tick(); period_end = Z; stop_req = 0; expect_out(F, Z, Z, 0, 0, 0, 0, "R6 nothing parked");
    // hold drain with staggered ends
    tick(); period_end = 4'b0011; expect_out(F, Z, Z, 0, 0, 0, 0, "R3 drain start");
    tick(); period_end = Z; expect_out(4'b1100, Z, Z, 0, 0, 0, 0, "R3 partial park");
    tick(); period_end = 4'b1100; expect_out(4'b1100, Z, Z, 0, 0, 0, 0, "R3 wait last");
    tick(); period_end = Z; upd_req = 1; expect_out(Z, Z, Z, 1, 1, 0, 1, "R3 held with irq");
    tick(); upd_req = 0; expect_out(Z, Z, Z, 1, 1, 1, 1, "R9 commit in hold");
    tick(); irq_clr = 1; expect_out(Z, Z, Z, 1, 1, 0, 1, "R10 irq sticky");
    tick(); irq_clr = 0; hold_req = 0; expect_out(Z, Z, Z, 1, 1, 0, 0, "R10 irq cleared");
    tick(); expect_out(Z, Z, F, 0, 0, 0, 0, "R4 restart after hold");
    tick(); period_end = 4'b0001; round_num = 8'd3; expect_out(F, Z, Z, 0, 0, 0, 0, "R4 run after hold");
    // round of three lead periods
    tick(); period_end = Z; expect_out(F, Z, Z, 0, 0, 0, 0, "R7 after 1");
    tick(); period_end = 4'b0001; expect_out(F, Z, Z, 0, 0, 0, 0, "R7 pulse 2");
    tick(); period_end = Z; expect_out(F, Z, Z, 0, 0, 0, 0, "R7 after 2");
    tick(); period_end = 4'b0001; expect_out(F, Z, Z, 0, 0, 0, 0, "R7 pulse 3");
    tick(); period_end = Z; expect_out(Z, Z, Z, 0, 0, 0, 0, "R7 finished");
    tick(); expect_out(Z, Z, Z, 0, 0, 0, 0, "R7 stays finished");
    // disable from running
    grp_en = 0;
    tick(); grp_en = 1; round_num = '0; expect_out(Z, Z, Z, 0, 0, 0, 0, "R11 idle");
    tick(); expect_out(Z, Z, F, 0, 0, 0, 0, "R11 restart");
    tick(); grp_en = 0; expect_out(F, Z, Z, 0, 0, 0, 0, "R11 running");
    tick(); expect_out(Z, Z, Z, 0, 0, 0, 0, "R11 disabled");
    tick(); tick();
    finished = 1;
    if (q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL monitor: actual %0d pending expected 0", q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule